// File: doc/BRIEF.md
# Reply Code Bit Decoder with Confidence Grading

This block turns one detected secondary-radar reply into its identity code. A start pulse from the frame detector, aligned with the leading-edge strobe of the first framing pulse on an already delayed data stream, starts an internal timeline. The timeline opens a three-cycle sampling window at each later code position. In every window the block keeps the sum amplitude and the sidelobe tag of the first edge it sees. After the special-position window closes, the block grades each of the twelve information bits. The grade compares the bit's amplitude with the reply's own reference amplitude and with the references of up to three other replies that are being decoded at the same time.

The controller has three states. `ST_IDLE` waits, and the *start* transition (frame_go while idle) moves it to `ST_SCAN`. `ST_SCAN` counts cycles and opens the sampling windows. The *window-end* transition, taken in the last cycle of the special-position window, moves it to `ST_REPORT` and registers the results. `ST_REPORT` lasts one cycle and drives `done`. The *report-complete* transition then returns it to `ST_IDLE`.

Top module: `reply_bit_decoder`

## Requirements
- R1: After reset, `done`, `spi_bit`, `id_code` and `conf` are all 0.
- R2: `frame_go` starts a decode only in `ST_IDLE`. A `frame_go` that arrives while a decode is running changes neither the timing nor the results of that decode.
- R3: The cycle in which `frame_go` is high is offset 0. Slot p (p = 1..14) is centred at offset 12·p. Slots 1..6 feed `id_code[0..5]` and slots 8..13 feed `id_code[6..11]`, with bit 0 the earliest. Slot 7 is the spare slot and feeds no output. Slot 14 is the second framing pulse.
- R4: An edge at offsets 12·p−1, 12·p or 12·p+1 counts for slot p, and only the first such edge is kept. An edge two cycles away from the centre counts for no slot.
- R5: The reference is `sum_amp` in the `frame_go` cycle. If `side_lobe` is high in that cycle, the reference is the amplitude kept for slot 14, or 0 if slot 14 saw no edge.
- R6: A bit with no kept edge, or with a kept amplitude below 16, decodes as 0 with `conf` = 1 (high confidence).
- R7: Two amplitudes correlate when they differ by at most 8. A main-beam bit that correlates with its own reference and with no valid other reference decodes as 1 with `conf` = 1.
- R8: A bit whose kept edge was sidelobe-tagged decodes as 0 with `conf` = 0.
- R9: For a main-beam bit: if it correlates only with a valid other reference, it decodes as 0 with `conf` = 0; if it correlates with neither reference, or with both, it decodes as 1 with `conf` = 0. A reference whose `other_vld` bit is low never correlates. Reference k sits in `other_ref[8k+7:8k]`.
- R10: `spi_bit` is 1 when an edge arrives at offset 203, 204 or 205 (36 cycles after the slot-14 centre), whatever its amplitude.
- R11: `done` is high for exactly one cycle, at offset 206. The results change only at that point and hold until the next `done`. `other_ref` and `other_vld` are read at offset 205.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame-valid start, aligned with the first framing edge |
| edge_in | input | 1 | Leading-edge strobe of the pulse video |
| sum_amp | input | 8 | Sum-channel amplitude |
| side_lobe | input | 1 | Sidelobe tag of the current pulse |
| other_ref | input | 24 | Reference amplitudes of up to three concurrent replies |
| other_vld | input | 3 | Valid bit for each concurrent reference |
| id_code | output | 12 | Decoded information bits |
| spi_bit | output | 1 | Special-position pulse present |
| conf | output | 12 | Per-bit confidence, 1 = high |
| done | output | 1 | Results-ready strobe |

## Verification
Every result becomes visible at offset 206: the window-end cycle at 205 registers it, and it shows on the ports one clock later. A behavioural model in the bench computes the expected code, confidence and special-position bit from the pulse list of each frame. The bench drives inputs and samples outputs on the falling edge, and compares `done` and all outputs on every cycle. It expects `done` only at offset 206 and the previous frame's results in every other cycle, so an early, late or doubled result is caught in the very cycle it appears.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } rbd_state_e;

    localparam int SLOT_F2   = 14;
    localparam int SLOT_SPI  = 15;
    localparam int INFO_BITS = 12;

    // slot index feeding information bit j (slot 7 is the spare)
    function automatic int info_slot(input int j);
        return (j < 6) ? j + 1 : j + 2;
    endfunction

    function automatic logic amp_near(input int a, input int b, input int tol);
        return ((a - b) <= tol) && ((b - a) <= tol);
    endfunction

endpackage

// File: rtl/rbd_timer.sv
module rbd_timer
    import rbd_pkg::*;
#(
    parameter int PITCH   = 12,
    parameter int SPI_GAP = 36,
    parameter int SLOT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              start,
    output logic              report,
    output logic              last,
    output logic              win_valid,
    output logic [SLOT_W-1:0] win_slot
);
    localparam int F2_OFF   = SLOT_F2 * PITCH;
    localparam int SPI_OFF  = F2_OFF + SPI_GAP;
    localparam int LAST_OFF = SPI_OFF + 1;
    localparam int CNT_W    = $clog2(LAST_OFF + 2);
    localparam logic [CNT_W-1:0] SPI_LO  = CNT_W'(SPI_OFF - 1);
    localparam logic [CNT_W-1:0] SPI_HI  = CNT_W'(SPI_OFF + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LAST_OFF);

    rbd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             scanning;
    logic [SLOT_F2:1] slot_hit;
    logic             spi_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_SCAN;
            ST_SCAN:   if (cnt_q == CNT_END) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (state_q == ST_SCAN)      cnt_q <= cnt_q + 1'b1;
        else if (state_q == ST_IDLE && go) cnt_q <= CNT_W'(1);
        else                              cnt_q <= '0;
    end

    always_comb begin
        start    = (state_q == ST_IDLE) && go;
        scanning = (state_q == ST_SCAN);
        report   = (state_q == ST_REPORT);
        last     = scanning && (cnt_q == CNT_END);
    end

    for (genvar p = 1; p <= SLOT_F2; p++) begin : g_win
        localparam logic [CNT_W-1:0] LO = CNT_W'(p * PITCH - 1);
        localparam logic [CNT_W-1:0] HI = CNT_W'(p * PITCH + 1);
        assign slot_hit[p] = scanning && (cnt_q >= LO) && (cnt_q <= HI);
    end

    assign spi_hit   = scanning && (cnt_q >= SPI_LO) && (cnt_q <= SPI_HI);
    assign win_valid = (|slot_hit) | spi_hit;

    always_comb begin
        win_slot = '0;
        for (int p = 1; p <= SLOT_F2; p++) begin
            if (slot_hit[p]) win_slot = SLOT_W'(p);
        end
        if (spi_hit) win_slot = SLOT_W'(SLOT_SPI);
    end

    // R11: the count advances by one every scanning cycle
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !last) |=> (scanning && cnt_q == $past(cnt_q) + 1'b1));

    // R11: the report state lasts exactly one cycle
    a_r11_report_once: assert property (@(posedge clk) disable iff (!rst_n)
        report |=> (state_q == ST_IDLE));

    // R2: a start begins the scan at offset 1
    a_r2_start_scan: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (scanning && cnt_q == CNT_W'(1)));

    // R2: a go during the scan does not disturb it
    a_r2_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && go && !last) |=> scanning);

endmodule

// File: rtl/rbd_capture.sv
module rbd_capture
    import rbd_pkg::*;
#(
    parameter int AMP_W  = 8,
    parameter int SLOT_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic                                 edge_in,
    input  logic [AMP_W-1:0]                     amp,
    input  logic                                 sl,
    input  logic                                 win_valid,
    input  logic [SLOT_W-1:0]                    win_slot,
    output logic [AMP_W-1:0]                     f1_amp,
    output logic                                 f1_sl,
    output logic [AMP_W-1:0]                     f2_amp,
    output logic [INFO_BITS-1:0]                 info_found,
    output logic [INFO_BITS-1:0][AMP_W-1:0]      info_amp,
    output logic [INFO_BITS-1:0]                 info_sl,
    output logic                                 spi_found
);
    logic take;
    logic f2_seen;

    assign take = win_valid && edge_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f1_amp <= '0;
            f1_sl  <= 1'b0;
        end else if (start) begin
            f1_amp <= amp;
            f1_sl  <= sl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            f2_amp  <= '0;
            f2_seen <= 1'b0;
        end else if (take && win_slot == SLOT_W'(SLOT_F2) && !f2_seen) begin
            f2_amp  <= amp;
            f2_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start)                           spi_found <= 1'b0;
        else if (take && win_slot == SLOT_W'(SLOT_SPI)) spi_found <= 1'b1;
    end

    for (genvar j = 0; j < INFO_BITS; j++) begin : g_bit
        localparam int P = info_slot(j);

        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                info_found[j] <= 1'b0;
                info_amp[j]   <= '0;
                info_sl[j]    <= 1'b0;
            end else if (take && win_slot == SLOT_W'(P) && !info_found[j]) begin
                info_found[j] <= 1'b1;
                info_amp[j]   <= amp;
                info_sl[j]    <= sl;
            end
        end

        // R4: once an edge is kept for a bit, later edges leave it alone
        a_r4_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (info_found[j] && !start) |=> (info_found[j] && $stable(info_amp[j])));
    end

endmodule

// File: rtl/rbd_grade.sv
module rbd_grade
    import rbd_pkg::*;
#(
    parameter int AMP_W   = 8,
    parameter int N_OTHER = 3,
    parameter int TOL     = 8,
    parameter int MIN_AMP = 16
) (
    input  logic [AMP_W-1:0]                f1_amp,
    input  logic                            f1_sl,
    input  logic [AMP_W-1:0]                f2_amp,
    input  logic [INFO_BITS-1:0]            info_found,
    input  logic [INFO_BITS-1:0][AMP_W-1:0] info_amp,
    input  logic [INFO_BITS-1:0]            info_sl,
    input  logic [N_OTHER-1:0][AMP_W-1:0]   other_ref,
    input  logic [N_OTHER-1:0]              other_vld,
    output logic [INFO_BITS-1:0]            code_bits,
    output logic [INFO_BITS-1:0]            conf_bits
);
    logic [AMP_W-1:0] ref_amp;

    assign ref_amp = f1_sl ? f2_amp : f1_amp;

    for (genvar j = 0; j < INFO_BITS; j++) begin : g_bit
        logic present;
        logic own;
        logic oth;

        always_comb begin
            present = info_found[j] && (info_amp[j] >= AMP_W'(MIN_AMP));
            own     = amp_near(int'(info_amp[j]), int'(ref_amp), TOL);
            oth     = 1'b0;
            for (int k = 0; k < N_OTHER; k++) begin
                if (other_vld[k] && amp_near(int'(info_amp[j]), int'(other_ref[k]), TOL))
                    oth = 1'b1;
            end
            if (!present) begin
                code_bits[j] = 1'b0;
                conf_bits[j] = 1'b1;
            end else if (info_sl[j]) begin
                code_bits[j] = 1'b0;
                conf_bits[j] = 1'b0;
            end else if (own && !oth) begin
                code_bits[j] = 1'b1;
                conf_bits[j] = 1'b1;
            end else if (!own && oth) begin
                code_bits[j] = 1'b0;
                conf_bits[j] = 1'b0;
            end else begin
                code_bits[j] = 1'b1;
                conf_bits[j] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/reply_bit_decoder.sv
module reply_bit_decoder
    import rbd_pkg::*;
#(
    parameter int AMP_W   = 8,
    parameter int N_OTHER = 3,
    parameter int PITCH   = 12,
    parameter int SPI_GAP = 36,
    parameter int TOL     = 8,
    parameter int MIN_AMP = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_go,
    input  logic                       edge_in,
    input  logic [AMP_W-1:0]           sum_amp,
    input  logic                       side_lobe,
    input  logic [N_OTHER*AMP_W-1:0]   other_ref,
    input  logic [N_OTHER-1:0]         other_vld,
    output logic [INFO_BITS-1:0]       id_code,
    output logic                       spi_bit,
    output logic [INFO_BITS-1:0]       conf,
    output logic                       done
);
    localparam int SLOT_W = $clog2(SLOT_SPI + 1);

    logic                            start, last, win_valid;
    logic [SLOT_W-1:0]               win_slot;
    logic [AMP_W-1:0]                f1_amp, f2_amp;
    logic                            f1_sl, spi_found;
    logic [INFO_BITS-1:0]            info_found, info_sl;
    logic [INFO_BITS-1:0][AMP_W-1:0] info_amp;
    logic [N_OTHER-1:0][AMP_W-1:0]   oref_arr;
    logic [INFO_BITS-1:0]            code_w, conf_w;

    for (genvar k = 0; k < N_OTHER; k++) begin : g_oref
        assign oref_arr[k] = other_ref[k*AMP_W +: AMP_W];
    end

    rbd_timer #(.PITCH(PITCH), .SPI_GAP(SPI_GAP), .SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (frame_go),
        .start     (start),
        .report    (done),
        .last      (last),
        .win_valid (win_valid),
        .win_slot  (win_slot)
    );

    rbd_capture #(.AMP_W(AMP_W), .SLOT_W(SLOT_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .edge_in    (edge_in),
        .amp        (sum_amp),
        .sl         (side_lobe),
        .win_valid  (win_valid),
        .win_slot   (win_slot),
        .f1_amp     (f1_amp),
        .f1_sl      (f1_sl),
        .f2_amp     (f2_amp),
        .info_found (info_found),
        .info_amp   (info_amp),
        .info_sl    (info_sl),
        .spi_found  (spi_found)
    );

    rbd_grade #(.AMP_W(AMP_W), .N_OTHER(N_OTHER), .TOL(TOL), .MIN_AMP(MIN_AMP)) u_grade (
        .f1_amp     (f1_amp),
        .f1_sl      (f1_sl),
        .f2_amp     (f2_amp),
        .info_found (info_found),
        .info_amp   (info_amp),
        .info_sl    (info_sl),
        .other_ref  (oref_arr),
        .other_vld  (other_vld),
        .code_bits  (code_w),
        .conf_bits  (conf_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_code <= '0;
            conf    <= '0;
            spi_bit <= 1'b0;
        end else if (last) begin
            id_code <= code_w;
            conf    <= conf_w;
            spi_bit <= spi_found |
                       (edge_in && win_valid && win_slot == SLOT_W'(SLOT_SPI));
        end
    end

    // R11: done is a single-cycle strobe
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done follows the close of the special-position window
    a_r11_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(win_valid));

    // R11: results hold while no report is taking place
    a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(last)) |-> ($stable(id_code) && $stable(conf)));

endmodule

// File: tb/reply_bit_decoder_test.sv
module reply_bit_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_go, edge_in, side_lobe;
    logic [7:0]  sum_amp;
    logic [23:0] other_ref;
    logic [2:0]  other_vld;
    logic [11:0] id_code, conf;
    logic        spi_bit, done;

    always #2 clk = ~clk;

    reply_bit_decoder uut (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .edge_in(edge_in),
        .sum_amp(sum_amp), .side_lobe(side_lobe), .other_ref(other_ref),
        .other_vld(other_vld), .id_code(id_code), .spi_bit(spi_bit),
        .conf(conf), .done(done)
    );

    localparam int NONE = 99;
    int  off[16];
    int  amp[16];
    bit  sl[16];
    int  errors = 0;
    int  checks = 0;
    logic [11:0] exp_code = '0, exp_conf = '0;
    logic        exp_spi  = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic bit close(input int a, input int b);
        return (a - b <= 8) && (b - a <= 8);
    endfunction

    function automatic bit inwin(input int o);
        return (o >= -1) && (o <= 1);
    endfunction

    task automatic model(output logic [11:0] c, output logic [11:0] f, output logic s);
        int refv;
        refv = sl[0] ? (inwin(off[14]) ? amp[14] : 0) : amp[0];
        for (int j = 0; j < 12; j++) begin
            int p;
            bit pres, own, oth;
            p    = (j < 6) ? j + 1 : j + 2;
            pres = inwin(off[p]) && amp[p] >= 16;
            own  = close(amp[p], refv);
            oth  = 0;
            for (int k = 0; k < 3; k++)
                if (other_vld[k] && close(amp[p], int'(other_ref[8*k +: 8]))) oth = 1;
            if (!pres)            begin c[j] = 0; f[j] = 1; end
            else if (sl[p])       begin c[j] = 0; f[j] = 0; end
            else if (own && !oth) begin c[j] = 1; f[j] = 1; end
            else if (!own && oth) begin c[j] = 0; f[j] = 0; end
            else                  begin c[j] = 1; f[j] = 0; end
        end
        s = inwin(off[15]);
    endtask

    task automatic clear_frame();
        for (int p = 0; p < 16; p++) begin
            off[p] = NONE; amp[p] = 0; sl[p] = 0;
        end
        off[0] = 0;  amp[0] = 100;
        off[14] = 0; amp[14] = 100;
        other_vld = '0;
        other_ref = '0;
    endtask

    task automatic put(input int p, input int o, input int a, input bit s);
        off[p] = o; amp[p] = a; sl[p] = s;
    endtask

    task automatic run_frame(input string tag, input int extra_go);
        logic [11:0] nc, nf;
        logic        ns;
        model(nc, nf, ns);
        for (int cyc = 0; cyc < 216; cyc++) begin
            @(negedge clk);
            check(done === (cyc == 206), tag, "done (R11)", int'(done), int'(cyc == 206));
            if (cyc == 206) begin
                exp_code = nc; exp_conf = nf; exp_spi = ns;
            end
            check(id_code === exp_code, tag, "id_code", int'(id_code), int'(exp_code));
            check(conf === exp_conf, tag, "conf", int'(conf), int'(exp_conf));
            check(spi_bit === exp_spi, tag, "spi_bit (R10)", int'(spi_bit), int'(exp_spi));
            frame_go  = (cyc == 0) || (cyc == extra_go);
            edge_in   = 1'b0;
            sum_amp   = 8'h5A;
            side_lobe = 1'b0;
            for (int p = 0; p < 16; p++) begin
                int nom;
                nom = (p < 15) ? 12 * p : 204;
                if (off[p] != NONE && nom + off[p] == cyc) begin
                    edge_in   = 1'b1;
                    sum_amp   = 8'(amp[p]);
                    side_lobe = sl[p];
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_go = 0; edge_in = 0; side_lobe = 0;
        sum_amp = '0; other_ref = '0; other_vld = '0;
        repeat (4) @(negedge clk);
        check(done === 1'b0, "R1", "done", int'(done), 0);
        check(id_code === 12'h0, "R1", "id_code", int'(id_code), 0);
        check(conf === 12'h0, "R1", "conf", int'(conf), 0);
        check(spi_bit === 1'b0, "R1", "spi_bit", int'(spi_bit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R6 R7: slot mapping, low amplitude, correlation edge at 8 and 9
        clear_frame();
        put(1, 0, 104, 0); put(3, 0, 96, 0); put(4, 0, 10, 0);
        put(5, 0, 109, 0); put(7, 0, 100, 0); put(8, 0, 100, 0);
        put(13, 0, 108, 0); put(15, 0, 60, 0);
        run_frame("R3/R6/R7", -1);

        // R4 R10: jitter of one accepted, two rejected; late special pulse
        clear_frame();
        put(1, -1, 100, 0); put(2, 1, 100, 0); put(3, -2, 100, 0);
        put(4, 2, 100, 0);  put(5, 0, 100, 0); put(11, 1, 99, 0);
        put(14, 1, 100, 0); put(15, 1, 30, 0);
        run_frame("R4/R10", -1);

        // R5: sidelobe first framing pulse, reference taken from the second
        clear_frame();
        put(0, 0, 200, 1); put(14, -1, 50, 0);
        put(1, 0, 52, 0);  put(2, 0, 200, 0); put(9, 0, 45, 0);
        run_frame("R5", -1);

        // R8 R9: sidelobe bit and concurrent reference cases
        clear_frame();
        other_ref = {8'd100, 8'd112, 8'd40};
        other_vld = 3'b011;
        put(1, 0, 100, 1); put(2, 0, 42, 0); put(3, 0, 94, 0);
        put(4, 0, 70, 0);  put(5, 0, 106, 0); put(10, 0, 100, 0);
        run_frame("R8/R9", -1);

        // R2 R10: second go while busy ignored; early-by-two special pulse
        clear_frame();
        put(2, 0, 101, 0); put(6, 1, 99, 0); put(12, -1, 100, 0);
        put(15, -2, 80, 0);
        run_frame("R2/R10", 50);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule